// File: doc/BRIEF.md
# Byte-Wide Slave Configuration Loader

This block takes in a configuration stream one byte per rising edge of an externally driven configuration clock. It assembles the bytes into fixed-length frames, checks the marker bytes at each end of every frame, and reports the whole frame on a parallel output. It does no CRC. It keeps no length count. Configuration is complete once a set number of frames has arrived. At that point the block raises a done flag and ignores all further traffic until it is reset.

The block captures nothing unless the three-bit mode input holds the byte-loading code. The first rising edge that sees the code only arms the loader. Bytes are taken on every edge after that, with no gaps. If the mode changes during a frame, the partial frame is dropped and the loader returns to idle. The active-low program input clears every piece of state.

Top module: `byte_cfg_loader`

## Requirements
- R1: While `prog_n` is low and directly after it is released, `cfg_done`, `cfg_err` and `frame_valid` are 0 and `frame_data` is all zeros.
- R2: When `mode` is any value other than binary 010, no byte is captured and `frame_valid` stays 0.
- R3: The edge at which the loader leaves idle with `mode` = 010 captures no byte. The first byte of a frame is taken on the next rising edge.
- R4: Bytes are captured on consecutive rising edges with no gaps. `frame_data` holds the first byte of the frame in bits [127:120] and the last byte in bits [7:0] (default 16-byte frame).
- R5: `frame_valid` rises in the cycle after the edge that captures the last byte of a frame. It stays high for exactly one cycle.
- R6: The first byte of a frame must be 8'hFE and the last must be 8'hFF. If either differs, `cfg_err` becomes 1 together with that frame's `frame_valid`. `cfg_err` then stays 1 until `prog_n` goes low. A frame with bad markers is still emitted.
- R7: `cfg_done` rises together with the `frame_valid` of frame number NUM_FRAMES (4 by default). Frames count whether or not they have marker errors. After that, bytes are ignored: `frame_valid` stays 0, `frame_data` holds its value and `cfg_done` stays 1.
- R8: If `mode` leaves 010 in the middle of a frame, the partial frame is discarded. When 010 returns, the first edge is again skipped and the next frame starts at its first byte.
- R9: Pulling `prog_n` low clears `cfg_done` and `cfg_err` and returns the loader to idle, so a fresh load can begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Externally supplied configuration clock |
| prog_n | input | 1 | Active-low program/reset, asynchronous assert |
| mode | input | 3 | Mode selector; 3'b010 enables byte loading |
| din | input | 8 | Configuration data byte |
| frame_valid | output | 1 | One-cycle pulse marking a complete frame |
| frame_data | output | 128 | Assembled frame, first byte in the top bits |
| cfg_err | output | 1 | Sticky marker mismatch flag |
| cfg_done | output | 1 | All frames received; further bytes ignored |

## Verification
The bench puts a distinct dummy byte on the arming edge. A loader that captured that edge would finish the frame one edge early, and its data would be shifted by one byte. It drops the mode in the middle of a frame and then resumes. A design that kept the partial bytes would emit a spliced frame. It checks that `cfg_err` is still 0 one edge before a frame with a bad start marker ends. An early check would set the flag too soon, and a check that was not sticky would lose it on the next clean frame. It also streams whole valid frames after completion. A design that kept loading after done would produce extra pulses or change `frame_data`.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_DONE = 2'd2
   } cfgl_state_e;

endpackage

// File: rtl/cfgl_mode_dec.sv
module cfgl_mode_dec #(
   parameter int         MODE_W    = 3,
   parameter logic [2:0] MODE_CODE = 3'b010
) (
   input  logic [MODE_W-1:0] mode,
   output logic              sel
);

   generate
      if (MODE_W != 3) begin : g_bad_w
         $error("cfgl_mode_dec: MODE_W must be 3");
      end
   endgenerate

   always_comb begin
      sel = (mode == MODE_CODE);
   end

endmodule

// File: rtl/cfgl_seq.sv
module cfgl_seq
   import cfgl_pkg::*;
#(
   parameter int NUM_FRAMES = 4
) (
   input  logic cfg_clk,
   input  logic prog_n,
   input  logic sel,
   input  logic frame_last,
   output logic cap_en,
   output logic done
);

   localparam int FCNT_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES + 1) : 1;
   localparam logic [FCNT_W-1:0] FCNT_LAST = FCNT_W'(NUM_FRAMES - 1);

   cfgl_state_e       state_q, state_d;
   logic [FCNT_W-1:0] fcnt_q;
   logic              done_q;

   always_comb begin
      cap_en = (state_q == ST_LOAD) && sel;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (sel) state_d = ST_LOAD;
         ST_LOAD: begin
            if (!sel)
               state_d = ST_IDLE;
            else if (frame_last && (fcnt_q == FCNT_LAST))
               state_d = ST_DONE;
         end
         ST_DONE: state_d = ST_DONE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge cfg_clk or negedge prog_n) begin
      if (!prog_n) begin
         state_q <= ST_IDLE;
         fcnt_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (frame_last)
            fcnt_q <= fcnt_q + FCNT_W'(1);
         if (state_d == ST_DONE)
            done_q <= 1'b1;
      end
   end

   assign done = done_q;

   a_r2_idle_no_capture: assert property (@(posedge cfg_clk) disable iff (!prog_n)
      !sel |-> !cap_en);

   a_r3_arm_edge_skipped: assert property (@(posedge cfg_clk) disable iff (!prog_n)
      cap_en |-> $past(sel));

   a_r7_done_sticky: assert property (@(posedge cfg_clk) disable iff (!prog_n)
      done |=> done);

   a_r7_no_capture_after_done: assert property (@(posedge cfg_clk) disable iff (!prog_n)
      done |-> !cap_en);

endmodule

// File: rtl/cfgl_frame_asm.sv
module cfgl_frame_asm
   import cfgl_pkg::*;
#(
   parameter int FRAME_BYTES  = 16,
   parameter bit LANE_INDEXED = 1'b0,
   localparam int FRAME_W     = FRAME_BYTES * BYTE_W
) (
   input  logic               cfg_clk,
   input  logic               prog_n,
   input  logic               cap_en,
   input  logic [BYTE_W-1:0]  din,
   output logic               frame_last,
   output logic [FRAME_W-1:0] asm_next,
   output logic               frame_valid,
   output logic [FRAME_W-1:0] frame_data
);

   localparam int POS_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
   localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BYTES - 1);

   logic [POS_W-1:0]   pos_q;
   logic               valid_q;
   logic [FRAME_W-1:0] data_q;

   always_comb begin
      frame_last = cap_en && (pos_q == POS_LAST);
   end

   // Byte position inside the current frame; any idle edge restarts it.
   always_ff @(posedge cfg_clk or negedge prog_n) begin
      if (!prog_n)
         pos_q <= '0;
      else if (!cap_en || frame_last)
         pos_q <= '0;
      else
         pos_q <= pos_q + POS_W'(1);
   end

   generate
      if (LANE_INDEXED) begin : g_lanes
         for (genvar i = 0; i < FRAME_BYTES; i++) begin : g_lane
            logic [BYTE_W-1:0] lane_q;
            logic              hit;
            assign hit = cap_en && (pos_q == POS_W'(i));
            always_ff @(posedge cfg_clk or negedge prog_n) begin
               if (!prog_n)
                  lane_q <= '0;
               else if (hit)
                  lane_q <= din;
            end
            assign asm_next[(FRAME_BYTES-1-i)*BYTE_W +: BYTE_W] = hit ? din : lane_q;
         end
      end else begin : g_shift
         logic [FRAME_W-1:0] sr_q;
         always_ff @(posedge cfg_clk or negedge prog_n) begin
            if (!prog_n)
               sr_q <= '0;
            else if (cap_en)
               sr_q <= {sr_q[FRAME_W-BYTE_W-1:0], din};
         end
         assign asm_next = {sr_q[FRAME_W-BYTE_W-1:0], din};
      end
   endgenerate

   always_ff @(posedge cfg_clk or negedge prog_n) begin
      if (!prog_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= frame_last;
         if (frame_last)
            data_q <= asm_next;
      end
   end

   assign frame_valid = valid_q;
   assign frame_data  = data_q;

   a_r4_pos_steps: assert property (@(posedge cfg_clk) disable iff (!prog_n)
      (cap_en && !frame_last) |=> (pos_q == $past(pos_q) + POS_W'(1)));

   a_r8_pos_restart: assert property (@(posedge cfg_clk) disable iff (!prog_n)
      !cap_en |=> (pos_q == '0));

   a_r5_valid_single: assert property (@(posedge cfg_clk) disable iff (!prog_n)
      frame_valid |=> !frame_valid);

   a_r7_data_held: assert property (@(posedge cfg_clk) disable iff (!prog_n)
      !$past(frame_last) |-> $stable(frame_data));

endmodule

// File: rtl/cfgl_marker_chk.sv
module cfgl_marker_chk
   import cfgl_pkg::*;
#(
   parameter int                FRAME_BYTES = 16,
   parameter logic [BYTE_W-1:0] HEAD_MARK   = 8'hFE,
   parameter logic [BYTE_W-1:0] TAIL_MARK   = 8'hFF,
   localparam int               FRAME_W     = FRAME_BYTES * BYTE_W
) (
   input  logic               cfg_clk,
   input  logic               prog_n,
   input  logic               frame_last,
   input  logic [FRAME_W-1:0] asm_next,
   output logic               err
);

   logic bad_head, bad_tail, err_q;

   always_comb begin
      bad_head = asm_next[FRAME_W-1 -: BYTE_W] != HEAD_MARK;
      bad_tail = asm_next[BYTE_W-1:0] != TAIL_MARK;
   end

   always_ff @(posedge cfg_clk or negedge prog_n) begin
      if (!prog_n)
         err_q <= 1'b0;
      else if (frame_last && (bad_head || bad_tail))
         err_q <= 1'b1;
   end

   assign err = err_q;

   a_r6_err_sticky: assert property (@(posedge cfg_clk) disable iff (!prog_n)
      err |=> err);

   a_r6_err_only_at_frame_end: assert property (@(posedge cfg_clk) disable iff (!prog_n)
      $rose(err) |-> $past(frame_last));

endmodule

// File: rtl/byte_cfg_loader.sv
module byte_cfg_loader
   import cfgl_pkg::*;
#(
   parameter int                MODE_W       = 3,
   parameter logic [2:0]        MODE_CODE    = 3'b010,
   parameter int                FRAME_BYTES  = 16,
   parameter int                NUM_FRAMES   = 4,
   parameter logic [BYTE_W-1:0] HEAD_MARK    = 8'hFE,
   parameter logic [BYTE_W-1:0] TAIL_MARK    = 8'hFF,
   parameter bit                LANE_INDEXED = 1'b0,
   localparam int               FRAME_W      = FRAME_BYTES * BYTE_W
) (
   input  logic               cfg_clk,
   input  logic               prog_n,
   input  logic [MODE_W-1:0]  mode,
   input  logic [BYTE_W-1:0]  din,
   output logic               frame_valid,
   output logic [FRAME_W-1:0] frame_data,
   output logic               cfg_err,
   output logic               cfg_done
);

   generate
      if (FRAME_BYTES < 2) begin : g_bad_frame
         $error("byte_cfg_loader: FRAME_BYTES must be at least 2");
      end
      if (NUM_FRAMES < 1) begin : g_bad_count
         $error("byte_cfg_loader: NUM_FRAMES must be at least 1");
      end
   endgenerate

   logic               sel;
   logic               cap_en;
   logic               frame_last;
   logic [FRAME_W-1:0] asm_next;

   cfgl_mode_dec #(
      .MODE_W    (MODE_W),
      .MODE_CODE (MODE_CODE)
   ) u_dec (
      .mode (mode),
      .sel  (sel)
   );

   cfgl_seq #(
      .NUM_FRAMES (NUM_FRAMES)
   ) u_seq (
      .cfg_clk    (cfg_clk),
      .prog_n     (prog_n),
      .sel        (sel),
      .frame_last (frame_last),
      .cap_en     (cap_en),
      .done       (cfg_done)
   );

   cfgl_frame_asm #(
      .FRAME_BYTES  (FRAME_BYTES),
      .LANE_INDEXED (LANE_INDEXED)
   ) u_asm (
      .cfg_clk     (cfg_clk),
      .prog_n      (prog_n),
      .cap_en      (cap_en),
      .din         (din),
      .frame_last  (frame_last),
      .asm_next    (asm_next),
      .frame_valid (frame_valid),
      .frame_data  (frame_data)
   );

   cfgl_marker_chk #(
      .FRAME_BYTES (FRAME_BYTES),
      .HEAD_MARK   (HEAD_MARK),
      .TAIL_MARK   (TAIL_MARK)
   ) u_chk (
      .cfg_clk    (cfg_clk),
      .prog_n     (prog_n),
      .frame_last (frame_last),
      .asm_next   (asm_next),
      .err        (cfg_err)
   );

   a_r7_done_with_valid: assert property (@(posedge cfg_clk) disable iff (!prog_n)
      $rose(cfg_done) |-> frame_valid);

endmodule

// File: tb/byte_cfg_loader_tb.sv
module byte_cfg_loader_tb;

   localparam int CLK_NS = 4;
   localparam int FB     = 16;
   localparam int FW     = FB * 8;

   logic          cfg_clk = 1'b0;
   logic          prog_n  = 1'b0;
   logic [2:0]    mode    = 3'b000;
   logic [7:0]    din     = 8'h00;
   logic          frame_valid;
   logic [FW-1:0] frame_data;
   logic          cfg_err;
   logic          cfg_done;

   int n_checks = 0;
   int n_fail   = 0;
   int vcount   = 0;
   logic [FW-1:0] last_data = '0;
   logic pre_valid, pre_err, pre_done;

   always #(CLK_NS/2) cfg_clk = ~cfg_clk;

   byte_cfg_loader u_dut (
      .cfg_clk     (cfg_clk),
      .prog_n      (prog_n),
      .mode        (mode),
      .din         (din),
      .frame_valid (frame_valid),
      .frame_data  (frame_data),
      .cfg_err     (cfg_err),
      .cfg_done    (cfg_done)
   );

   // Pulse monitor, sampled after edge updates settle.
   always @(posedge cfg_clk) begin
      #1;
      if (prog_n && frame_valid) begin
         vcount++;
         last_data = frame_data;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [FW-1:0] act, input logic [FW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   function automatic logic [7:0] fbyte(input logic [7:0] seed, input int i,
                                        input logic [7:0] head, input logic [7:0] tail);
      if (i == 0) return head;
      if (i == FB - 1) return tail;
      return seed + 8'(i * 3);
   endfunction

   function automatic logic [FW-1:0] fvec(input logic [7:0] seed,
                                          input logic [7:0] head, input logic [7:0] tail);
      logic [FW-1:0] v = '0;
      for (int i = 0; i < FB; i++) v = {v[FW-9:0], fbyte(seed, i, head, tail)};
      return v;
   endfunction

   // Called at a falling edge; returns at the next falling edge.
   task automatic push(input logic [7:0] b, input logic [2:0] m);
      din  = b;
      mode = m;
      @(negedge cfg_clk);
   endtask

   task automatic send_frame(input logic [7:0] seed, input logic [7:0] head,
                             input logic [7:0] tail);
      for (int i = 0; i < FB - 1; i++) push(fbyte(seed, i, head, tail), 3'b010);
      pre_valid = frame_valid;
      pre_err   = cfg_err;
      pre_done  = cfg_done;
      push(fbyte(seed, FB - 1, head, tail), 3'b010);
   endtask

   task automatic do_reset();
      prog_n = 1'b0;
      mode   = 3'b000;
      din    = 8'h00;
      repeat (3) @(negedge cfg_clk);
      check(cfg_done == 0 && cfg_err == 0 && frame_valid == 0, "R1", "flags in reset",
            {cfg_done, cfg_err, frame_valid}, '0);
      prog_n = 1'b1;
      @(negedge cfg_clk);
      check(frame_data == '0, "R1", "frame_data after reset", frame_data, '0);
      check(cfg_done == 0 && cfg_err == 0, "R9", "done/err cleared",
            {cfg_done, cfg_err}, '0);
   endtask

   task automatic t_other_modes();
      logic [2:0] mlist [7] = '{3'd0, 3'd1, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
      for (int k = 0; k < 7; k++)
         for (int i = 0; i < FB + 4; i++) push(fbyte(8'h30, i % FB, 8'hFE, 8'hFF), mlist[k]);
      check(vcount == 0, "R2", "no frames in other modes", FW'(vcount), '0);
      check(cfg_done == 0 && cfg_err == 0, "R2", "flags idle", {cfg_done, cfg_err}, '0);
   endtask

   task automatic t_first_frame();
      push(8'hAA, 3'b010);  // arming edge, must not be captured
      send_frame(8'h10, 8'hFE, 8'hFF);
      check(pre_valid == 0, "R5", "no pulse before last byte", FW'(pre_valid), '0);
      check(frame_valid == 1, "R5", "pulse after last byte", FW'(frame_valid), 1);
      check(frame_data == fvec(8'h10, 8'hFE, 8'hFF), "R3", "arm edge skipped, frame A",
            frame_data, fvec(8'h10, 8'hFE, 8'hFF));
      check(frame_data[FW-1 -: 8] == 8'hFE && frame_data[7:0] == 8'hFF, "R4",
            "first byte on top", frame_data, fvec(8'h10, 8'hFE, 8'hFF));
      check(cfg_err == 0 && cfg_done == 0, "R6", "good frame no error",
            {cfg_err, cfg_done}, '0);
   endtask

   task automatic t_abort();
      push(fbyte(8'h50, 0, 8'hFE, 8'hFF), 3'b010);
      check(frame_valid == 0, "R5", "pulse lasts one cycle", FW'(frame_valid), '0);
      for (int i = 1; i < 5; i++) push(fbyte(8'h50, i, 8'hFE, 8'hFF), 3'b010);
      push(8'h55, 3'b000);
      push(8'h77, 3'b010);  // re-arm edge
      send_frame(8'h60, 8'hFE, 8'hFF);
      check(vcount == 2, "R8", "one frame after abort", FW'(vcount), 2);
      check(last_data == fvec(8'h60, 8'hFE, 8'hFF), "R8", "frame B intact",
            last_data, fvec(8'h60, 8'hFE, 8'hFF));
   endtask

   task automatic t_bad_head();
      send_frame(8'h70, 8'h12, 8'hFF);
      check(pre_err == 0, "R6", "no error before frame end", FW'(pre_err), '0);
      check(cfg_err == 1 && frame_valid == 1, "R6", "error with pulse",
            {cfg_err, frame_valid}, 2'b11);
      check(frame_data == fvec(8'h70, 8'h12, 8'hFF), "R6", "bad frame still emitted",
            frame_data, fvec(8'h70, 8'h12, 8'hFF));
   endtask

   task automatic t_done();
      send_frame(8'h80, 8'hFE, 8'hFF);
      check(pre_done == 0, "R7", "not done before last frame", FW'(pre_done), '0);
      check(cfg_done == 1 && frame_valid == 1, "R7", "done with fourth pulse",
            {cfg_done, frame_valid}, 2'b11);
      check(cfg_err == 1, "R6", "error sticky over good frame", FW'(cfg_err), 1);
      for (int i = 0; i < 3 * FB; i++) push(fbyte(8'h90, i % FB, 8'hFE, 8'hFF), 3'b010);
      check(vcount == 4, "R7", "no pulses after done", FW'(vcount), 4);
      check(frame_data == fvec(8'h80, 8'hFE, 8'hFF), "R7", "data held after done",
            frame_data, fvec(8'h80, 8'hFE, 8'hFF));
      check(cfg_done == 1, "R7", "done held", FW'(cfg_done), 1);
   endtask

   task automatic t_reload_bad_tail();
      do_reset();
      push(8'hC3, 3'b010);
      send_frame(8'hA0, 8'hFE, 8'h00);
      check(vcount == 5, "R9", "reload after reset", FW'(vcount), 5);
      check(cfg_err == 1 && cfg_done == 0, "R6", "bad tail sets error",
            {cfg_err, cfg_done}, 2'b10);
      check(frame_data == fvec(8'hA0, 8'hFE, 8'h00), "R3", "arm skip after reset",
            frame_data, fvec(8'hA0, 8'hFE, 8'h00));
   endtask

   initial begin
      #(CLK_NS * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      @(negedge cfg_clk);
      do_reset();
      t_other_modes();
      t_first_frame();
      t_abort();
      t_bad_head();
      t_done();
      t_reload_bad_tail();
      summary();
      $finish;
   end

endmodule